// File: doc/BRIEF.md
# Lockable Secure-Memory Region Controller

This block guards one system-management memory window. It keeps three configuration words: the entry address of the management handler, the window base address, and the window mask with its two enable bits. Privileged software programs these words over a small register bus. Software then sets a lock bit, and after that the three words can no longer be changed.

A write-only key register gives a controlled way back out of the locked state. The key can only be stored while the block is unlocked. Once the lock is set, a key write compares its data with the stored key. A match clears the lock. A mismatch leaves the lock set and advances a saturating miss counter.

Every memory access presented to the block gets a registered verdict: whether it hits the protected window, the read data to return, whether a write may pass, and a violation pulse for a normal-mode write that was dropped. A registered status bit shows whether the handler entry address lies inside the enabled window.

Top module: `smr_ctrl`

## Requirements
- R1: After reset, every configuration word is zero, the lock is clear, no key is stored, the miss counter is zero, and all registered outputs are zero.
- R2: Configuration registers are reached only when `cfg_priv` is 1. The offsets are: 0 handler base, 1 window base, 2 window mask, 3 hardware configuration (bit 0 is the lock), 4 key, 5 miss counter (read-only). A normal-mode write changes nothing, and a normal-mode read returns zero. Read data appears on `cfg_rdata` one cycle after `cfg_rd`.
- R3: While the lock is set, writes to offsets 0, 1 and 2 are ignored.
- R4: Protection is on only when mask bits 0 and 1 are both 1. An address hits the window when (address AND mask) equals (base AND mask), counting only mask bits 17 and above.
- R5: A normal-mode read that hits an enabled window returns all-ones data. Privileged reads, and reads outside the window, return the memory data unchanged.
- R6: A normal-mode write that hits an enabled window is not passed on (`mem_we_o`=0), and `viol_o` pulses for one cycle. Privileged writes, and writes outside the window, are passed on.
- R7: Reading the key offset always returns zero.
- R8: A key write while unlocked stores the key. A key write while locked whose data equals a nonzero stored key clears the lock.
- R9: A key write while locked that does not match leaves the lock set and increments the 8-bit miss counter. The counter saturates at 255.
- R10: A stored key of zero never clears the lock.
- R11: `handler_in_region_o` is 1 exactly when protection is on and the handler base hits the window. It updates one cycle after the configuration changes.
- R12: While the lock is set, writing 0 to the hardware configuration register does not clear the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_priv | input | 1 | Register access is privileged-mode |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | W | Register write data |
| cfg_rdata | output | W | Registered read data |
| mem_valid | input | 1 | Memory access present |
| mem_write | input | 1 | Access is a write |
| mem_priv | input | 1 | Access is privileged-mode |
| mem_addr | input | W | Access address |
| mem_rdata_i | input | W | Data from memory for reads |
| mem_hit_o | output | 1 | Access hit the enabled window |
| mem_we_o | output | 1 | Write is passed to memory |
| mem_rdata_o | output | W | Read data returned to requester |
| viol_o | output | 1 | Dropped normal-mode write pulse |
| handler_in_region_o | output | 1 | Handler base lies inside the window |

## Verification
Accesses are made at addresses inside and outside the window, in both privileged and normal mode, for both reads and writes. This separates the forced all-ones and dropped-write paths from the pass-through path. The mask is also tried with each enable bit cleared on its own, which shows that protection needs both bits. The key is exercised with a matching value, a wrong value, a zero key, and enough wrong tries to reach saturation. These cases separate unlocking from counting and from the locked freeze.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [2:0] {
    RA_HBASE = 3'd0,
    RA_RBASE = 3'd1,
    RA_RMASK = 3'd2,
    RA_HWCFG = 3'd3,
    RA_KEY   = 3'd4,
    RA_MISS  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/smr_regs.sv
module smr_regs #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic             priv,
  input  logic [2:0]       addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     hbase,
  output logic [W-1:0]     rbase,
  output logic [W-1:0]     rmask,
  output logic             lock,
  output logic [CNT_W-1:0] miss_cnt
);
  import smr_pkg::*;

  logic [W-1:0] key_q;
  logic         wen;
  logic         key_hit;
  logic [W-1:0] rmux;

  assign wen     = wr && priv;
  assign key_hit = (key_q != '0) && (wdata == key_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hbase    <= '0;
      rbase    <= '0;
      rmask    <= '0;
      lock     <= 1'b0;
      key_q    <= '0;
      miss_cnt <= '0;
    end else if (wen) begin
      case (addr)
        RA_HBASE: if (!lock) hbase <= wdata;
        RA_RBASE: if (!lock) rbase <= wdata;
        RA_RMASK: if (!lock) rmask <= wdata;
        RA_HWCFG: if (!lock) lock <= wdata[0];
        RA_KEY: begin
          if (!lock) begin
            key_q <= wdata;
          end else if (key_hit) begin
            lock <= 1'b0;
          end else if (miss_cnt != '1) begin
            miss_cnt <= miss_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_HBASE: rmux = hbase;
      RA_RBASE: rmux = rbase;
      RA_RMASK: rmux = rmask;
      RA_HWCFG: rmux = {{(W-1){1'b0}}, lock};
      RA_MISS:  rmux = {{(W-CNT_W){1'b0}}, miss_cnt};
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= priv ? rmux : '0;
  end
endmodule

// File: rtl/smr_match.sv
module smr_match #(
  parameter int W   = 32,
  parameter int LSB = 17
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] base,
  input  logic [W-1:0] mask,
  output logic         hit
);
  localparam logic [W-1:0] HI = {{(W-LSB){1'b1}}, {LSB{1'b0}}};

  logic         en;
  logic [W-1:0] m;

  assign en  = mask[0] & mask[1];
  assign m   = mask & HI;
  assign hit = en && ((addr & m) == (base & m));
endmodule

// File: rtl/smr_filter.sv
module smr_filter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         write,
  input  logic         priv,
  input  logic         hit,
  input  logic [W-1:0] rdata_i,
  output logic         hit_o,
  output logic         we_o,
  output logic [W-1:0] rdata_o,
  output logic         viol_o
);
  logic block;
  assign block = valid && hit && !priv;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o   <= 1'b0;
      we_o    <= 1'b0;
      rdata_o <= '0;
      viol_o  <= 1'b0;
    end else begin
      hit_o   <= valid && hit;
      we_o    <= valid && write && !block;
      viol_o  <= write && block;
      if (valid && !write) rdata_o <= block ? '1 : rdata_i;
    end
  end
endmodule

// File: rtl/smr_ctrl.sv
module smr_ctrl #(
  parameter int W     = 32,
  parameter int LSB   = 17,
  parameter int CNT_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr,
  input  logic         cfg_rd,
  input  logic         cfg_priv,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         mem_valid,
  input  logic         mem_write,
  input  logic         mem_priv,
  input  logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata_i,
  output logic         mem_hit_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_rdata_o,
  output logic         viol_o,
  output logic         handler_in_region_o
);
  logic [W-1:0]     hbase, rbase, rmask;
  logic             lock;
  logic [CNT_W-1:0] miss_cnt;
  logic             acc_hit, hnd_hit;

  smr_regs #(.W(W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .priv(cfg_priv),
    .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .hbase(hbase), .rbase(rbase), .rmask(rmask), .lock(lock),
    .miss_cnt(miss_cnt)
  );

  smr_match #(.W(W), .LSB(LSB)) u_acc_match (
    .addr(mem_addr), .base(rbase), .mask(rmask), .hit(acc_hit)
  );

  smr_match #(.W(W), .LSB(LSB)) u_hnd_match (
    .addr(hbase), .base(rbase), .mask(rmask), .hit(hnd_hit)
  );

  smr_filter #(.W(W)) u_filter (
    .clk(clk), .rst(rst), .valid(mem_valid), .write(mem_write),
    .priv(mem_priv), .hit(acc_hit), .rdata_i(mem_rdata_i),
    .hit_o(mem_hit_o), .we_o(mem_we_o), .rdata_o(mem_rdata_o),
    .viol_o(viol_o)
  );

  always_ff @(posedge clk) begin
    if (rst) handler_in_region_o <= 1'b0;
    else     handler_in_region_o <= hnd_hit;
  end
endmodule

// File: rtl/smr_ctrl_chk.sv
module smr_ctrl_chk #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic             cfg_priv,
  input logic [2:0]       cfg_addr,
  input logic [W-1:0]     cfg_wdata,
  input logic [W-1:0]     cfg_rdata,
  input logic [W-1:0]     hbase,
  input logic [W-1:0]     rmask,
  input logic             lock,
  input logic [CNT_W-1:0] miss_cnt,
  input logic             mem_valid,
  input logic             mem_write,
  input logic             mem_priv,
  input logic             mem_hit_o,
  input logic             mem_we_o,
  input logic             viol_o
);
  p_lock_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (lock && cfg_wr && cfg_addr == 3'd0) |=> $stable(hbase));

  p_key_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr == 3'd4) |=> (cfg_rdata == '0));

  p_zero_key_r10: assert property (@(posedge clk) disable iff (rst)
    (lock && cfg_wr && cfg_priv && cfg_addr == 3'd4 && cfg_wdata == '0) |=> lock);

  p_lock_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (lock && cfg_wr && cfg_addr == 3'd3) |=> lock);

  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt == '1) |=> (miss_cnt == '1));

  p_viol_drop_r6: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> !mem_we_o);

  p_priv_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write && mem_priv) |=> (mem_we_o && !viol_o));

  p_enable_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && rmask[1:0] != 2'b11) |=> !mem_hit_o);
endmodule

bind smr_ctrl smr_ctrl_chk #(.W(W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_priv(cfg_priv), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .hbase(hbase), .rmask(rmask), .lock(lock),
  .miss_cnt(miss_cnt), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_priv(mem_priv), .mem_hit_o(mem_hit_o), .mem_we_o(mem_we_o),
  .viol_o(viol_o)
);

// File: tb/smr_ctrl_tb.sv
module smr_ctrl_tb_top;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         cfg_wr, cfg_rd, cfg_priv;
  logic [2:0]   cfg_addr;
  logic [W-1:0] cfg_wdata, cfg_rdata;
  logic         mem_valid, mem_write, mem_priv;
  logic [W-1:0] mem_addr, mem_rdata_i, mem_rdata_o;
  logic         mem_hit_o, mem_we_o, viol_o, handler_in_region_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [W-1:0] BASE = 32'h0800_0000;
  localparam logic [W-1:0] MASK = 32'hFFF0_0003;
  localparam logic [W-1:0] IN_A = 32'h0801_2340;
  localparam logic [W-1:0] OUTA = 32'h0810_0000;
  localparam logic [W-1:0] MEMD = 32'h5A5A_5A5A;

  always #(CLK_PERIOD/2) clk = ~clk;

  smr_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_priv(cfg_priv), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_priv(mem_priv), .mem_addr(mem_addr), .mem_rdata_i(mem_rdata_i),
    .mem_hit_o(mem_hit_o), .mem_we_o(mem_we_o), .mem_rdata_o(mem_rdata_o),
    .viol_o(viol_o), .handler_in_region_o(handler_in_region_o)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d, logic p = 1'b1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_priv = p; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_priv = 1'b1;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d, input logic p = 1'b1);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_priv = p; cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
    cfg_rd = 1'b0; cfg_priv = 1'b1;
  endtask

  task automatic acc(logic w, logic p, logic [W-1:0] a);
    @(negedge clk);
    mem_valid = 1'b1; mem_write = w; mem_priv = p; mem_addr = a;
    @(negedge clk);
    mem_valid = 1'b0; mem_write = 1'b0;
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d);
      chk("R1 reg zero", d, '0);
    end
    chk("R1 outputs", {mem_hit_o, mem_we_o, viol_o, handler_in_region_o}, '0);
  endtask

  task automatic t_priv_access;
    logic [W-1:0] d;
    wr(3'd0, 32'h1111_0000, 1'b0);
    rd(3'd0, d);
    chk("R2 normal write ignored", d, '0);
    wr(3'd1, BASE);
    wr(3'd2, MASK);
    rd(3'd1, d);
    chk("R2 base readback", d, BASE);
    rd(3'd2, d, 1'b0);
    chk("R2 normal read zero", d, '0);
  endtask

  task automatic t_filter;
    acc(1'b0, 1'b0, IN_A);
    chk("R5 normal read inside", mem_rdata_o, '1);
    chk("R4 hit inside", mem_hit_o, 1);
    acc(1'b0, 1'b1, IN_A);
    chk("R5 priv read inside", mem_rdata_o, MEMD);
    acc(1'b0, 1'b0, OUTA);
    chk("R5 normal read outside", mem_rdata_o, MEMD);
    chk("R4 miss outside", mem_hit_o, 0);
    acc(1'b0, 1'b0, 32'h0800_FFFF ^ 32'h0001_0000);
    chk("R4 low bits ignored", mem_hit_o, 1);
    acc(1'b1, 1'b0, IN_A);
    chk("R6 normal write dropped", {mem_we_o, viol_o}, 2'b01);
    @(negedge clk);
    chk("R6 viol one pulse", viol_o, 0);
    acc(1'b1, 1'b1, IN_A);
    chk("R6 priv write pass", {mem_we_o, viol_o}, 2'b10);
    acc(1'b1, 1'b0, OUTA);
    chk("R6 outside write pass", {mem_we_o, viol_o}, 2'b10);
  endtask

  task automatic t_enables;
    wr(3'd2, MASK & ~32'h1);
    acc(1'b0, 1'b0, IN_A);
    chk("R4 bit0 clear off", mem_rdata_o, MEMD);
    wr(3'd2, MASK & ~32'h2);
    acc(1'b1, 1'b0, IN_A);
    chk("R4 bit1 clear off", {mem_we_o, viol_o}, 2'b10);
    wr(3'd2, MASK);
  endtask

  task automatic t_handler;
    wr(3'd0, 32'h0900_0000);
    @(negedge clk);
    chk("R11 handler outside", handler_in_region_o, 0);
    wr(3'd0, 32'h0800_8000);
    @(negedge clk);
    chk("R11 handler inside", handler_in_region_o, 1);
  endtask

  task automatic t_lock_key;
    logic [W-1:0] d;
    wr(3'd4, 32'hC0DE_1234);
    rd(3'd4, d);
    chk("R7 key read zero", d, '0);
    wr(3'd3, 32'h1);
    rd(3'd3, d);
    chk("R8 locked", d, 32'h1);
    wr(3'd1, 32'h0400_0000);
    rd(3'd1, d);
    chk("R3 base frozen", d, BASE);
    wr(3'd2, 32'h0);
    acc(1'b0, 1'b0, IN_A);
    chk("R3 mask frozen", mem_rdata_o, '1);
    wr(3'd3, 32'h0);
    rd(3'd3, d);
    chk("R12 lock held", d, 32'h1);
    wr(3'd4, 32'hDEAD_0000);
    rd(3'd3, d);
    chk("R9 mismatch keeps lock", d, 32'h1);
    rd(3'd5, d);
    chk("R9 count one", d, 32'd1);
    wr(3'd4, 32'hC0DE_1234);
    rd(3'd3, d);
    chk("R8 match unlocks", d, 32'h0);
    wr(3'd1, 32'h0400_0000);
    rd(3'd1, d);
    chk("R8 writable after unlock", d, 32'h0400_0000);
    wr(3'd1, BASE);
  endtask

  task automatic t_zero_key;
    logic [W-1:0] d;
    wr(3'd4, 32'h0);
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd3, d);
    chk("R10 zero key no unlock", d, 32'h1);
    rd(3'd5, d);
    chk("R9 count two", d, 32'd2);
  endtask

  task automatic t_saturate;
    logic [W-1:0] d;
    for (int i = 0; i < 260; i++) wr(3'd4, 32'h0BAD_0000 + 32'(i));
    rd(3'd5, d);
    chk("R9 saturate", d, 32'd255);
    rd(3'd3, d);
    chk("R9 still locked", d, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cfg_wr = 0; cfg_rd = 0; cfg_priv = 1; cfg_addr = '0; cfg_wdata = '0;
    mem_valid = 0; mem_write = 0; mem_priv = 0; mem_addr = '0;
    mem_rdata_i = MEMD;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_priv_access();
    t_filter();
    t_enables();
    t_handler();
    t_lock_key();
    t_zero_key();
    t_saturate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule